// File: doc/BRIEF.md
# Serial DAC Input Frame Receiver

This block is the digital front end of a serial-input voltage DAC. It runs entirely on the serial clock: while the active-low frame select is low it shifts the serial data line in on each falling clock edge, most significant bit first, and once sixteen bits have arrived it splits the word into a two-bit power-down mode field and a fourteen-bit converter code and commits both at once. The committed code feeds the resistor string, and the mode is presented as an output-stage select plus a power-down flag for the analog output switches, which are not part of this block.

A frame that is cut short by frame select rising early leaves no trace. Once a frame has committed, further clock edges are ignored until frame select has gone high and then low again. The outputs are plain registers with no back-pressure: the receiver cannot stall the sender, so the one-period update strobe acts as a valid with no matching ready, and a consumer must take the code in the period it is flagged or read it later from the held register.

Top module: `dac_frame_rx`

## Requirements
- R1: A frame starts when frame select is low; data is sampled on falling serial clock edges, most significant bit first, sixteen bits per frame.
- R2: Frame bits 15:14 form the mode field and bits 13:0 the straight-binary code presented on `code_o`.
- R3: `stage_o` follows the committed mode: 00 amplifier drives the output, 01 output to ground through 1 kΩ, 10 through 100 kΩ, 11 output open; `pd_o` is 1 for every mode other than 00.
- R4: Code and mode are committed on the sixteenth falling edge of a frame, and `upd_o` is high for exactly the one serial clock period that follows that edge.
- R5: If frame select rises before the sixteenth falling edge, code, mode and `upd_o` stay unchanged and the partial bits do not leak into the next frame.
- R6: Falling edges after the sixteenth, while frame select stays low, change nothing until frame select has gone high and low again.
- R7: Reset sets the code to zero, the mode to 00 and `upd_o` to 0.
- R8: A power-down frame loads its code field like any other frame; the code stays held while `pd_o` is 1.
- R9: Each valid frame produces exactly one `upd_o` pulse and no other pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Power-on reset, active high, asynchronous |
| sclk_i | input | 1 | Serial clock; data taken on falling edges |
| frame_n_i | input | 1 | Frame select, active low |
| sdata_i | input | 1 | Serial data, MSB first |
| code_o | output | 14 | Committed converter code |
| stage_o | output | 2 | Output-stage select (see R3) |
| pd_o | output | 1 | Power-down flag |
| upd_o | output | 1 | One-period commit strobe |

## Verification
The hardest situations to reach are an abort that lands on the very last bit, where frame select rises after the fifteenth edge but before the sixteenth, and a frame select held low long after a commit while the clock keeps running. The stimulus clocks exactly fifteen bits of a distinctive word and then raises select, then sends a clean frame to show no stale bit survived; a second directed case clocks twenty-four bits in one low period with inverted trailing data and counts strobes to show only the first sixteen mattered.

// File: rtl/dac_frame_rx_pkg.sv
package dac_frame_rx_pkg;
  localparam int CODE_W = 14;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    STG_DRIVE    = 2'b00,
    STG_GND_LOW  = 2'b01,
    STG_GND_HIGH = 2'b10,
    STG_OPEN     = 2'b11
  } stage_e;
endpackage

// File: rtl/frame_shift.sv
// Serial-to-parallel shifter with saturating bit counter.
// Cleared asynchronously whenever frame select is high or reset is active.
module frame_shift #(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               sclk_i,
  input  logic               clr_i,
  input  logic               sdata_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               last_o
);
  logic [FRAME_W-2:0] sreg;
  logic [CNT_W-1:0]   cnt;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  always_ff @(negedge sclk_i or posedge clr_i) begin
    if (clr_i) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (cnt != CNT_FULL) begin
      sreg <= {sreg[FRAME_W-3:0], sdata_i};
      cnt  <= cnt + 1'b1;
    end
  end

  // The word as it stands once the current bit is added.
  assign word_o = {sreg, sdata_i};
  assign last_o = (cnt == CNT_LAST);
endmodule

// File: rtl/frame_commit.sv
// Holding registers for code and mode, plus the one-period update strobe.
module frame_commit #(
  parameter int CODE_W = 14,
  parameter int MODE_W = 2,
  localparam int FRAME_W = CODE_W + MODE_W
) (
  input  logic               sclk_i,
  input  logic               rst_i,
  input  logic               last_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               upd_o
);
  always_ff @(negedge sclk_i or posedge rst_i) begin
    if (rst_i) begin
      code_o <= '0;
      mode_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= last_i;
      if (last_i) begin
        code_o <= word_i[CODE_W-1:0];
        mode_o <= word_i[FRAME_W-1:CODE_W];
      end
    end
  end
endmodule

// File: rtl/mode_decode.sv
// Maps the committed mode field to the output-stage select and power-down flag.
module mode_decode
  import dac_frame_rx_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output stage_e            stage_o,
  output logic              pd_o
);
  always_comb begin
    unique case (mode_i)
      2'b00:   stage_o = STG_DRIVE;
      2'b01:   stage_o = STG_GND_LOW;
      2'b10:   stage_o = STG_GND_HIGH;
      default: stage_o = STG_OPEN;
    endcase
    pd_o = (stage_o != STG_DRIVE);
  end
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_frame_rx_pkg::*;
(
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] stage_o,
  output logic              pd_o,
  output logic              upd_o
);
  localparam int FRAME_W = CODE_W + MODE_W;

  logic               shift_clr;
  logic [FRAME_W-1:0] word;
  logic               last;
  logic [MODE_W-1:0]  mode;
  stage_e             stage;

  assign shift_clr = rst_i | frame_n_i;

  frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .sclk_i (sclk_i),
    .clr_i  (shift_clr),
    .sdata_i(sdata_i),
    .word_o (word),
    .last_o (last)
  );

  frame_commit #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_commit (
    .sclk_i(sclk_i),
    .rst_i (rst_i),
    .last_i(last),
    .word_i(word),
    .code_o(code_o),
    .mode_o(mode),
    .upd_o (upd_o)
  );

  mode_decode u_dec (
    .mode_i (mode),
    .stage_o(stage),
    .pd_o   (pd_o)
  );

  assign stage_o = stage;
endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk (
  input logic        rst_i,
  input logic        sclk_i,
  input logic        frame_n_i,
  input logic [13:0] code_o,
  input logic [1:0]  stage_o,
  input logic        upd_o
);
  // Independent count of falling edges since frame select went low.
  logic [4:0] edges;
  logic       clr;
  assign clr = rst_i | frame_n_i;

  always_ff @(negedge sclk_i or posedge clr) begin
    if (clr)                edges <= '0;
    else if (edges != 5'd16) edges <= edges + 5'd1;
  end

  // R4: the sixteenth edge of a frame raises the strobe
  a_r4_strobe_on_last: assert property (@(negedge sclk_i) disable iff (rst_i || frame_n_i)
    (edges == 5'd15) |=> upd_o);

  // R9: no strobe from any other edge of a frame
  a_r9_no_stray_strobe: assert property (@(negedge sclk_i) disable iff (rst_i || frame_n_i)
    (edges != 5'd15) |=> !upd_o);

  // R4: strobe lasts one period
  a_r4_strobe_one_cycle: assert property (@(negedge sclk_i) disable iff (rst_i)
    upd_o |=> !upd_o);

  // R5: outputs only move together with the strobe
  a_r5_hold_without_strobe: assert property (@(negedge sclk_i) disable iff (rst_i)
    !upd_o |-> ($stable(code_o) && $stable(stage_o)));
endmodule

bind dac_frame_rx dac_frame_rx_chk u_chk (
  .rst_i    (rst_i),
  .sclk_i   (sclk_i),
  .frame_n_i(frame_n_i),
  .code_o   (code_o),
  .stage_o  (stage_o),
  .upd_o    (upd_o)
);

// File: tb/dac_frame_rx_test.sv
module dac_frame_rx_test;
  logic        rst, sclk, frame_n, sdata;
  logic [13:0] code;
  logic [1:0]  stage;
  logic        pd, upd;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 0;

  dac_frame_rx uut (
    .rst_i(rst), .sclk_i(sclk), .frame_n_i(frame_n), .sdata_i(sdata),
    .code_o(code), .stage_o(stage), .pd_o(pd), .upd_o(upd)
  );

  initial sclk = 1'b1;
  always #10 sclk = ~sclk;   // 50 MHz

  always @(posedge sclk) if (upd) pulses++;

  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    16'h3FFF, 16'h0000, 16'h5A5A, 16'h8001, 16'hC123, 16'h2AAA, 16'h1555
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Clock nbits bits of w (MSB first) with select low; returns at the rising
  // edge after the last falling edge, select still low.
  task automatic clock_bits(input logic [15:0] w, input int nbits);
    @(posedge sclk);
    frame_n = 1'b0;
    sdata   = w[15];
    for (int i = 0; i < nbits; i++) begin
      @(negedge sclk);
      @(posedge sclk);
      if (i < 15) sdata = w[14-i];
      else        sdata = ~sdata;
    end
  endtask

  task automatic end_frame();
    frame_n = 1'b1;
    @(negedge sclk);
    @(posedge sclk);
  endtask

  function automatic logic [1:0] exp_stage(input logic [15:0] w);
    return w[15:14];
  endfunction

  initial begin : wd
    repeat (20000) @(posedge sclk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] hold_code;
    logic [1:0]  hold_stage;
    int          p0;
    rst = 1'b1; frame_n = 1'b1; sdata = 1'b0;
    repeat (3) @(posedge sclk);
    rst = 1'b0;
    @(posedge sclk);
    // R7 reset state
    check("R7 code", code, 0);
    check("R7 stage", stage, 0);
    check("R7 pd", pd, 0);
    check("R7 upd", upd, 0);

    // Vector table: R1 R2 R3 R4 R8
    for (int v = 0; v < NV; v++) begin
      p0 = pulses;
      clock_bits(VEC[v], 16);
      check("R4 strobe", upd, 1);
      check("R2 code", code, VEC[v][13:0]);
      check("R3 stage", stage, exp_stage(VEC[v]));
      check("R3 pd", pd, (VEC[v][15:14] != 2'b00));
      end_frame();
      check("R4 strobe one period", upd, 0);
      check("R9 pulse count", pulses - p0, 1);
    end

    // R8: power-down frame, then abort while powered down keeps code
    clock_bits(16'h6ABC, 16);
    end_frame();
    check("R8 code in power-down", code, 14'h2ABC);
    check("R8 pd", pd, 1);

    // R5: abort after 15 bits
    hold_code = code; hold_stage = stage; p0 = pulses;
    clock_bits(16'h0F0F, 15);
    end_frame();
    repeat (3) @(posedge sclk);
    check("R5 code held", code, hold_code);
    check("R5 stage held", stage, hold_stage);
    check("R5 no strobe", pulses - p0, 0);

    // R5: abort after 4 bits, then a clean frame decodes correctly
    clock_bits(16'hFFFF, 4);
    end_frame();
    clock_bits(16'h4321, 16);
    end_frame();
    check("R5 clean frame after abort", code, 14'h0321);
    check("R1 mode after abort", stage, 2'b01);

    // R6: extra edges while select stays low
    p0 = pulses;
    clock_bits(16'h1234, 24);
    check("R6 code after extra edges", code, 14'h1234);
    check("R6 stage after extra edges", stage, 2'b00);
    end_frame();
    check("R6 single strobe", pulses - p0, 1);

    // R7: reset after activity
    clock_bits(16'hBEEF, 16);
    end_frame();
    rst = 1'b1;
    @(posedge sclk);
    rst = 1'b0;
    @(posedge sclk);
    check("R7 code after reset", code, 0);
    check("R7 stage after reset", stage, 0);
    check("R7 pd after reset", pd, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule